// File: doc/BRIEF.md
# Page Sharing Record Cache

This block sits in each tile next to the private last-level cache. Every miss or upgrade in that cache asks it whether the page holding the block is private to this tile or shared, and if it is shared, which other tiles must take part in the block-level exchange. Each stored record covers one page. It holds the page address, a sharer vector with one bit per tile, and a presence vector with one bit per block of the page that currently sits in the local caches.

When a page is not known locally, the block sends a page-information request to the page's home tile. It stalls the lookup until the reply arrives, then builds a record from the reply and finishes the lookup. The home tile can push a new sharer vector at any time, and the block acknowledges every such push. The local caches report each block fill and each block departure. When a record must give way, the block flushes only the blocks marked present, drops the record and tells the home tile that the page is released. The home tile can also order a full page flush, which flushes and drops the record without any release message.

Top module: `prc_page_record_cache`

## Requirements
- R1: After reset, `lk_ready` is 1 and `rsp_valid`, `pi_req_valid`, `flush_valid` and `put_valid` are all 0.
- R2: A lookup that hits returns `rsp_valid` exactly two cycles after it is accepted. When the stored sharer vector equals the one-hot bit of the local tile (`LOCAL_TILE`), the response has `rsp_shared`=0 and `rsp_targets`=0.
- R3: Any other stored sharer vector gives `rsp_shared`=1, with `rsp_targets` equal to the sharer vector with the local tile's bit cleared. This also applies when the local bit is absent from the vector.
- R4: A lookup that misses raises `pi_req_valid` for one cycle, with `pi_req_home` equal to the low 4 bits of the page address. No response is given until `pi_rep_valid` arrives. The response is then built from `pi_rep_sharers`, and a later lookup of the same page hits without a new request.
- R5: While a page-information request is outstanding, `lk_ready` stays 0 and no second request is issued, however long the reply takes.
- R6: A sharer update overwrites the sharer vector of a matching record. Every update, matching or not, is answered one cycle later by `up_ack_valid` with `up_ack_page` equal to the updated page. An update for an unknown page creates no record.
- R7: A block event with `blk_fill`=1 sets presence bit `blk_idx`, and one with `blk_fill`=0 clears it. `blk_idx` is physical address bits [11:6].
- R8: A flush-page command on a known page emits one `flush_valid` pulse per present block, in ascending block index, with `flush_page` equal to the page. It then drops the record and sends no release message. A later lookup of that page misses.
- R9: The record to replace is chosen in this order: an unused way; otherwise the least recently used of the records whose presence vector is all zero; otherwise the least recently used record. Hits and fills count as uses.
- R10: Replacing a record emits flush pulses for its present blocks in ascending index. After the last flush it emits one `put_valid` pulse with `put_page` equal to the old page and `put_home` equal to that page's low 4 bits. Only after that does the waiting lookup respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | PAGE_W | Page address of lookup |
| lk_ready | output | 1 | Lookup accepted this cycle when high |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_shared | output | 1 | 1 shared, 0 private |
| rsp_targets | output | TILES | Sharers other than this tile |
| pi_req_valid | output | 1 | Page-information request pulse |
| pi_req_page | output | PAGE_W | Requested page |
| pi_req_home | output | HOME_W | Home tile of requested page |
| pi_rep_valid | input | 1 | Page-information reply |
| pi_rep_sharers | input | TILES | Sharer vector in reply |
| up_valid | input | 1 | Sharer update from home |
| up_page | input | PAGE_W | Updated page |
| up_sharers | input | TILES | New sharer vector |
| up_ack_valid | output | 1 | Acknowledge of update |
| up_ack_page | output | PAGE_W | Page being acknowledged |
| blk_valid | input | 1 | Block arrival or departure event |
| blk_page | input | PAGE_W | Page of the block |
| blk_idx | input | BIDX_W | Block index within page |
| blk_fill | input | 1 | 1 arrival, 0 departure |
| fp_valid | input | 1 | Flush-page command from home |
| fp_page | input | PAGE_W | Page to flush |
| fp_ready | output | 1 | Flush-page command accepted when high |
| flush_valid | output | 1 | Block flush command pulse |
| flush_page | output | PAGE_W | Page of flushed block |
| flush_idx | output | BIDX_W | Index of flushed block |
| put_valid | output | 1 | Page release pulse to home |
| put_page | output | PAGE_W | Released page |
| put_home | output | HOME_W | Home tile of released page |

## Verification
Several kinds of internal fault surface within one lookup. A corrupted sharer vector appears as a wrong `rsp_targets` on the next hit. A lost record appears as an unexpected page-information request. Presence bits are not visible directly, so a wrong bit is caught by the flush burst from a flush-page command or from a replacement, where the list and order of `flush_idx` values expose it. A broken recency or empty-record preference shows up as the wrong `put_page` on the first replacement in a full set.

// File: rtl/prc_pkg.sv
// Shared definitions for the page record cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package prc_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,    // accept lookup or flush-page command
        ST_LOOK,    // tag compare for a lookup
        ST_WAIT,    // page-information request outstanding
        ST_WALK,    // emitting block flushes
        ST_DROP,    // invalidate record, optional release message
        ST_FILL,    // install record from reply and respond
        ST_FPLOOK   // tag compare for a flush-page command
    } prc_state_e;

endpackage

// File: rtl/prc_way_match.sv
// Associative tag compare over the ways of one set.
// Assumes at most one valid way holds a given page; reports the lowest match.
module prc_way_match #(
    parameter int WAYS   = 16,
    parameter int PAGE_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][PAGE_W-1:0] tags,
    input  logic [PAGE_W-1:0]           page,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);

    // Scan ways from the top so the lowest matching way wins
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid[w] && (tags[w] == page)) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/prc_victim_pick.sv
// Replacement choice for one set: unused way, else oldest empty record,
// else oldest record. Assumes ages form a permutation (0 = newest).
module prc_victim_pick #(
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0]            empty,
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    output logic [WAY_W-1:0]           way
);

    logic             inv_hit, emp_hit;
    logic [WAY_W-1:0] inv_way, emp_way, emp_age, old_way, old_age;

    // Three parallel searches, then a fixed priority among them
    always_comb begin
        inv_hit = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_hit = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
        emp_hit = 1'b0;
        emp_way = '0;
        emp_age = '0;
        old_way = '0;
        old_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] >= old_age) begin
                old_age = ages[w];
                old_way = WAY_W'(w);
            end
            if (empty[w] && (!emp_hit || ages[w] > emp_age)) begin
                emp_hit = 1'b1;
                emp_age = ages[w];
                emp_way = WAY_W'(w);
            end
        end
        way = inv_hit ? inv_way : (emp_hit ? emp_way : old_way);
    end

endmodule

// File: rtl/prc_lru_touch.sv
// Next recency ages of a set after one way is used.
// The used way becomes age 0; ways younger than it age by one.
module prc_lru_touch #(
    parameter int WAYS   = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][WAY_W-1:0] ages_next
);

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        // Per-way age update relative to the used way's old age
        always_comb begin
            if (WAY_W'(w) == way)
                ages_next[w] = '0;
            else if (ages[w] < ages[way])
                ages_next[w] = ages[w] + 1'b1;
            else
                ages_next[w] = ages[w];
        end
    end

endmodule

// File: rtl/prc_low_bit.sv
// Lowest set bit finder used to walk a presence vector upward.
// Assumes vec is non-zero when idx is used.
module prc_low_bit #(
    parameter int W      = 64,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rest
);

    // Priority search from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        rest = vec & (vec - W'(1));
    end

endmodule

// File: rtl/prc_page_record_cache.sv
// Per-tile cache of page sharing records. Answers private/shared lookups in
// two cycles, fetches unknown pages from the home tile, applies pushed sharer
// updates, tracks block presence and flushes present blocks on replacement
// or on command. Assumes one lookup or flush-page command in flight at a time;
// update and block events are applied in any cycle.
module prc_page_record_cache
    import prc_pkg::*;
#(
    parameter int TILES      = 16,
    parameter int LOCAL_TILE = 0,
    parameter int PAGE_W     = 20,
    parameter int BLKS       = 64,
    parameter int WAYS       = 16,
    parameter int SETS       = 4,
    localparam int HOME_W    = $clog2(TILES),
    localparam int BIDX_W    = $clog2(BLKS),
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_shared,
    output logic [TILES-1:0]  rsp_targets,
    output logic              pi_req_valid,
    output logic [PAGE_W-1:0] pi_req_page,
    output logic [HOME_W-1:0] pi_req_home,
    input  logic              pi_rep_valid,
    input  logic [TILES-1:0]  pi_rep_sharers,
    input  logic              up_valid,
    input  logic [PAGE_W-1:0] up_page,
    input  logic [TILES-1:0]  up_sharers,
    output logic              up_ack_valid,
    output logic [PAGE_W-1:0] up_ack_page,
    input  logic              blk_valid,
    input  logic [PAGE_W-1:0] blk_page,
    input  logic [BIDX_W-1:0] blk_idx,
    input  logic              blk_fill,
    input  logic              fp_valid,
    input  logic [PAGE_W-1:0] fp_page,
    output logic              fp_ready,
    output logic              flush_valid,
    output logic [PAGE_W-1:0] flush_page,
    output logic [BIDX_W-1:0] flush_idx,
    output logic              put_valid,
    output logic [PAGE_W-1:0] put_page,
    output logic [HOME_W-1:0] put_home
);

    localparam logic [TILES-1:0] LOCAL_MASK = {{(TILES-1){1'b0}}, 1'b1} << LOCAL_TILE;

    // Record storage, one slice per set
    logic [WAYS-1:0]             ent_v    [SETS];
    logic [WAYS-1:0][PAGE_W-1:0] ent_tag  [SETS];
    logic [WAYS-1:0][TILES-1:0]  ent_shr  [SETS];
    logic [WAYS-1:0][BLKS-1:0]   ent_pres [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  ent_age  [SETS];

    prc_state_e        state;
    logic [PAGE_W-1:0] cur_page, vic_page;
    logic [WAY_W-1:0]  vic_way;
    logic [TILES-1:0]  rep_shr;
    logic [BLKS-1:0]   walk_vec;
    logic              is_fp;

    logic [SET_W-1:0]  cur_set, up_set, blk_set;
    logic              cur_hit, up_hit, blk_hit;
    logic [WAY_W-1:0]  cur_way, up_way, blk_way, pick_way, touch_way;
    logic [WAYS-1:0]   cur_empty;
    logic [WAYS-1:0][WAY_W-1:0] ages_next;
    logic [BIDX_W-1:0] low_idx;
    logic [BLKS-1:0]   low_rest;
    logic [TILES-1:0]  hit_shr;

    assign cur_set   = cur_page[SET_W-1:0];
    assign up_set    = up_page[SET_W-1:0];
    assign blk_set   = blk_page[SET_W-1:0];
    assign hit_shr   = ent_shr[cur_set][cur_way];
    assign touch_way = (state == ST_FILL) ? vic_way : cur_way;
    assign lk_ready  = (state == ST_IDLE);
    assign fp_ready  = (state == ST_IDLE) && !lk_valid;
    assign put_home  = put_page[HOME_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_empty
        assign cur_empty[w] = ~|ent_pres[cur_set][w];
    end

    prc_way_match #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_m_cur (
        .valid(ent_v[cur_set]), .tags(ent_tag[cur_set]), .page(cur_page),
        .hit(cur_hit), .way(cur_way));

    prc_way_match #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_m_up (
        .valid(ent_v[up_set]), .tags(ent_tag[up_set]), .page(up_page),
        .hit(up_hit), .way(up_way));

    prc_way_match #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_m_blk (
        .valid(ent_v[blk_set]), .tags(ent_tag[blk_set]), .page(blk_page),
        .hit(blk_hit), .way(blk_way));

    prc_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid(ent_v[cur_set]), .empty(cur_empty), .ages(ent_age[cur_set]),
        .way(pick_way));

    prc_lru_touch #(.WAYS(WAYS)) u_lru (
        .ages(ent_age[cur_set]), .way(touch_way), .ages_next(ages_next));

    prc_low_bit #(.W(BLKS)) u_low (
        .vec(walk_vec), .idx(low_idx), .rest(low_rest));

    // Sequencer, record storage and side-event application
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur_page     <= '0;
            vic_page     <= '0;
            vic_way      <= '0;
            rep_shr      <= '0;
            walk_vec     <= '0;
            is_fp        <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_shared   <= 1'b0;
            rsp_targets  <= '0;
            pi_req_valid <= 1'b0;
            pi_req_page  <= '0;
            up_ack_valid <= 1'b0;
            up_ack_page  <= '0;
            flush_valid  <= 1'b0;
            flush_page   <= '0;
            flush_idx    <= '0;
            put_valid    <= 1'b0;
            put_page     <= '0;
            for (int s = 0; s < SETS; s++) begin
                ent_v[s] <= '0;
                for (int w = 0; w < WAYS; w++) ent_age[s][w] <= WAY_W'(w);
            end
        end else begin
            rsp_valid    <= 1'b0;
            pi_req_valid <= 1'b0;
            flush_valid  <= 1'b0;
            put_valid    <= 1'b0;
            up_ack_valid <= up_valid;
            up_ack_page  <= up_page;
            if (up_valid && up_hit) ent_shr[up_set][up_way] <= up_sharers;
            if (blk_valid && blk_hit) ent_pres[blk_set][blk_way][blk_idx] <= blk_fill;
            unique case (state)
                ST_IDLE: begin
                    if (lk_valid) begin
                        cur_page <= lk_page;
                        is_fp    <= 1'b0;
                        state    <= ST_LOOK;
                    end else if (fp_valid) begin
                        cur_page <= fp_page;
                        is_fp    <= 1'b1;
                        state    <= ST_FPLOOK;
                    end
                end
                ST_LOOK: begin
                    if (cur_hit) begin
                        rsp_valid        <= 1'b1;
                        rsp_shared       <= (hit_shr != LOCAL_MASK);
                        rsp_targets      <= (hit_shr == LOCAL_MASK) ? '0 : (hit_shr & ~LOCAL_MASK);
                        ent_age[cur_set] <= ages_next;
                        state            <= ST_IDLE;
                    end else begin
                        pi_req_valid <= 1'b1;
                        pi_req_page  <= cur_page;
                        state        <= ST_WAIT;
                    end
                end
                ST_FPLOOK: begin
                    if (cur_hit) begin
                        vic_way  <= cur_way;
                        vic_page <= cur_page;
                        walk_vec <= ent_pres[cur_set][cur_way];
                        state    <= (|ent_pres[cur_set][cur_way]) ? ST_WALK : ST_DROP;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (pi_rep_valid) begin
                        rep_shr <= pi_rep_sharers;
                        vic_way <= pick_way;
                        if (ent_v[cur_set][pick_way]) begin
                            vic_page <= ent_tag[cur_set][pick_way];
                            walk_vec <= ent_pres[cur_set][pick_way];
                            state    <= (|ent_pres[cur_set][pick_way]) ? ST_WALK : ST_DROP;
                        end else begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_WALK: begin
                    flush_valid <= 1'b1;
                    flush_page  <= vic_page;
                    flush_idx   <= low_idx;
                    walk_vec    <= low_rest;
                    if (low_rest == '0) state <= ST_DROP;
                end
                ST_DROP: begin
                    ent_v[cur_set][vic_way] <= 1'b0;
                    put_valid <= !is_fp;
                    put_page  <= vic_page;
                    state     <= is_fp ? ST_IDLE : ST_FILL;
                end
                ST_FILL: begin
                    ent_v[cur_set][vic_way]    <= 1'b1;
                    ent_tag[cur_set][vic_way]  <= cur_page;
                    ent_shr[cur_set][vic_way]  <= rep_shr;
                    ent_pres[cur_set][vic_way] <= '0;
                    ent_age[cur_set]           <= ages_next;
                    rsp_valid   <= 1'b1;
                    rsp_shared  <= (rep_shr != LOCAL_MASK);
                    rsp_targets <= (rep_shr == LOCAL_MASK) ? '0 : (rep_shr & ~LOCAL_MASK);
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pi_req_home = pi_req_page[HOME_W-1:0];

    AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !rsp_valid); // R2
    AST_PRIVATE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_shared) |-> (rsp_targets == '0)); // R2
    AST_TARGETS_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_targets[LOCAL_TILE]); // R3
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pi_req_valid |=> !pi_req_valid); // R4
    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        pi_req_valid |-> !lk_ready); // R5
    AST_FLUSH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !lk_ready); // R10
    AST_PUT_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        put_valid |-> !flush_valid); // R10

endmodule

// File: tb/sim_prc_page_record_cache.sv
// Self-checking bench for the page record cache (local tile 5, 4 sets x 16 ways).
module sim_prc_page_record_cache;

    localparam int CLK_PERIOD = 10;
    localparam int TILES = 16;
    localparam int PW    = 20;
    localparam int LT    = 5;
    localparam logic [15:0] LMASK = 16'h0020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [PW-1:0] lk_page = '0;
    logic lk_ready, rsp_valid, rsp_shared;
    logic [TILES-1:0] rsp_targets;
    logic pi_req_valid;
    logic [PW-1:0] pi_req_page;
    logic [3:0] pi_req_home;
    logic pi_rep_valid = 1'b0;
    logic [TILES-1:0] pi_rep_sharers = '0;
    logic up_valid = 1'b0;
    logic [PW-1:0] up_page = '0;
    logic [TILES-1:0] up_sharers = '0;
    logic up_ack_valid;
    logic [PW-1:0] up_ack_page;
    logic blk_valid = 1'b0;
    logic [PW-1:0] blk_page = '0;
    logic [5:0] blk_idx = '0;
    logic blk_fill = 1'b0;
    logic fp_valid = 1'b0;
    logic [PW-1:0] fp_page = '0;
    logic fp_ready, flush_valid, put_valid;
    logic [PW-1:0] flush_page, put_page;
    logic [5:0] flush_idx;
    logic [3:0] put_home;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int flog [64];
    logic [PW-1:0] flpg;

    always #(CLK_PERIOD/2) clk = ~clk;

    prc_page_record_cache #(.TILES(TILES), .LOCAL_TILE(LT), .PAGE_W(PW),
                            .BLKS(64), .WAYS(16), .SETS(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_page(lk_page), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_shared(rsp_shared), .rsp_targets(rsp_targets),
        .pi_req_valid(pi_req_valid), .pi_req_page(pi_req_page), .pi_req_home(pi_req_home),
        .pi_rep_valid(pi_rep_valid), .pi_rep_sharers(pi_rep_sharers),
        .up_valid(up_valid), .up_page(up_page), .up_sharers(up_sharers),
        .up_ack_valid(up_ack_valid), .up_ack_page(up_ack_page),
        .blk_valid(blk_valid), .blk_page(blk_page), .blk_idx(blk_idx), .blk_fill(blk_fill),
        .fp_valid(fp_valid), .fp_page(fp_page), .fp_ready(fp_ready),
        .flush_valid(flush_valid), .flush_page(flush_page), .flush_idx(flush_idx),
        .put_valid(put_valid), .put_page(put_page), .put_home(put_home));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic sample_flush(inout int nfl, inout int nput, inout logic [PW-1:0] pp);
        if (flush_valid) begin
            flog[nfl] = int'(flush_idx);
            flpg = flush_page;
            nfl++;
        end
        if (put_valid) begin
            nput++;
            pp = put_page;
            chk(put_home == put_page[3:0], "R10 put_home", 64'(put_home), 64'(put_page[3:0]));
        end
    endtask

    task automatic lookup(input logic [PW-1:0] pg, input logic [15:0] rep, input int delay,
                          output logic sh, output logic [15:0] tg, output int nreq,
                          output int lat, output int nfl, output int nput,
                          output logic [PW-1:0] pp);
        int cyc = 1;
        int wct = 0;
        bit got = 1'b0;
        bit pend = 1'b0;
        nreq = 0; lat = 0; nfl = 0; nput = 0; pp = '0; sh = 1'b0; tg = '0;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_page  = pg;
        @(negedge clk);
        lk_valid = 1'b0;
        while (!got && cyc < 400) begin
            pi_rep_valid = 1'b0;
            sample_flush(nfl, nput, pp);
            if (rsp_valid) begin
                got = 1'b1;
                lat = cyc;
                sh  = rsp_shared;
                tg  = rsp_targets;
            end
            if (pi_req_valid) begin
                nreq++;
                chk(pi_req_home == pg[3:0], "R4 home", 64'(pi_req_home), 64'(pg[3:0]));
                pend = 1'b1;
                wct  = delay;
            end else if (pend) begin
                if (wct == 1) chk(lk_ready == 1'b0, "R5 stall", 64'(lk_ready), 64'd0);
                if (wct == 0) begin
                    pi_rep_valid   = 1'b1;
                    pi_rep_sharers = rep;
                    pend = 1'b0;
                end else begin
                    wct--;
                end
            end
            if (!got) begin
                @(negedge clk);
                cyc++;
            end
        end
        pi_rep_valid = 1'b0;
        chk(got, "R4 response arrives", 64'(got), 64'd1);
    endtask

    task automatic block(input logic [PW-1:0] pg, input int idx, input bit fill);
        @(negedge clk);
        blk_valid = 1'b1; blk_page = pg; blk_idx = 6'(idx); blk_fill = fill;
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic update(input logic [PW-1:0] pg, input logic [15:0] shr);
        @(negedge clk);
        up_valid = 1'b1; up_page = pg; up_sharers = shr;
        @(negedge clk);
        up_valid = 1'b0;
        chk(up_ack_valid && up_ack_page == pg, "R6 ack", 64'(up_ack_page), 64'(pg));
    endtask

    task automatic flushpage(input logic [PW-1:0] pg, output int nfl, output int nput);
        logic [PW-1:0] pp = '0;
        nfl = 0; nput = 0;
        @(negedge clk);
        chk(fp_ready, "R8 fp_ready", 64'(fp_ready), 64'd1);
        fp_valid = 1'b1; fp_page = pg;
        @(negedge clk);
        fp_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            sample_flush(nfl, nput, pp);
            if (lk_ready) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic sh;
        logic [15:0] tg;
        int nreq, lat, nfl, nput;
        logic [PW-1:0] pp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(lk_ready == 1'b1, "R1 lk_ready", 64'(lk_ready), 64'd1);
        chk(!rsp_valid && !pi_req_valid && !flush_valid && !put_valid, "R1 pulses idle",
            64'({rsp_valid, pi_req_valid, flush_valid, put_valid}), 64'd0);

        // R4 miss, private reply, R5 long wait
        lookup(20'h00013, LMASK, 6, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 1, "R5 one request", 64'(nreq), 64'd1);
        chk(sh == 1'b0 && tg == 16'h0, "R4 private from reply", 64'({sh, tg}), 64'd0);
        chk(nfl == 0 && nput == 0, "R9 unused way, no eviction", 64'(nfl + nput), 64'd0);

        // R2 hit latency and private result
        lookup(20'h00013, 16'h0, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 0, "R4 later hit no request", 64'(nreq), 64'd0);
        chk(lat == 2, "R2 hit latency", 64'(lat), 64'd2);
        chk(sh == 1'b0 && tg == 16'h0, "R2 private", 64'({sh, tg}), 64'd0);

        // R3 shared with local bit
        lookup(20'h00022, 16'h0421, 1, sh, tg, nreq, lat, nfl, nput, pp);
        lookup(20'h00022, 16'h0, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(sh == 1'b1 && tg == 16'h0401, "R3 shared minus self", 64'({sh, tg}), 64'h10401);

        // R3 shared without local bit
        lookup(20'h00031, 16'h0003, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(sh == 1'b1 && tg == 16'h0003, "R3 shared no self bit", 64'({sh, tg}), 64'h10003);

        // R6 update overwrites sharers
        update(20'h00013, 16'h8020);
        lookup(20'h00013, 16'h0, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 0 && sh == 1'b1 && tg == 16'h8000, "R6 new sharers", 64'({sh, tg}), 64'h18000);

        // R6 update of unknown page: acked, no record
        update(20'h00AB9, 16'h0020);
        lookup(20'h00AB9, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 1, "R6 absent page not created", 64'(nreq), 64'd1);

        // R7 presence, R8 flush-page
        block(20'h00022, 3, 1'b1);
        block(20'h00022, 40, 1'b1);
        block(20'h00022, 63, 1'b1);
        block(20'h00022, 40, 1'b0);
        flushpage(20'h00022, nfl, nput);
        chk(nfl == 2, "R7 flush count", 64'(nfl), 64'd2);
        chk(flog[0] == 3 && flog[1] == 63, "R8 ascending flush", 64'({flog[0][7:0], flog[1][7:0]}), 64'h033F);
        chk(flpg == 20'h00022, "R8 flush page", 64'(flpg), 64'h22);
        chk(nput == 0, "R8 no release", 64'(nput), 64'd0);
        lookup(20'h00022, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 1, "R8 record dropped", 64'(nreq), 64'd1);

        // R9/R10 fill set 0
        for (int k = 0; k < 16; k++) begin
            lookup(20'h00100 + 20'(k * 4), LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        end
        block(20'h00100, 2, 1'b1);
        block(20'h00100, 1, 1'b1);
        for (int k = 1; k < 16; k++) begin
            if (k == 5) begin
                block(20'h00114, 7, 1'b1);
                block(20'h00114, 7, 1'b0);
            end else begin
                block(20'h00100 + 20'(k * 4), k, 1'b1);
            end
        end
        lookup(20'h00140, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nput == 1 && pp == 20'h00114, "R9 empty record preferred", 64'(pp), 64'h114);
        chk(nfl == 0, "R10 empty victim no flush", 64'(nfl), 64'd0);
        block(20'h00140, 9, 1'b1);
        lookup(20'h00144, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nput == 1 && pp == 20'h00100, "R9 least recent victim", 64'(pp), 64'h100);
        chk(nfl == 2 && flog[0] == 1 && flog[1] == 2, "R10 flush present blocks",
            64'({nfl[7:0], flog[0][7:0], flog[1][7:0]}), 64'h020102);
        chk(flpg == 20'h00100, "R10 flush page", 64'(flpg), 64'h100);
        chk(sh == 1'b0, "R10 response after release", 64'(sh), 64'd0);
        lookup(20'h00104, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 0, "R9 survivor still hits", 64'(nreq), 64'd0);
        lookup(20'h00100, LMASK, 0, sh, tg, nreq, lat, nfl, nput, pp);
        chk(nreq == 1, "R10 evicted page misses", 64'(nreq), 64'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule